// File: doc/BRIEF.md
# Multi-Channel Chunk DMA Engine

This block is a small DMA engine with a parameterised number of channels. Software sets it up through a 32-bit register interface and then starts or aborts channels with one shared command word. Each channel copies one contiguous chunk of bytes. A source or destination whose address mode is "fixed" is served by that channel's own device port. A side that walks upward or downward through addresses is served by a shared word-wide memory port.

Each beat reads one word from the source side and writes it to the destination side. Full beats carry four bytes. A last beat of one to three bytes is marked with byte enables. The length register counts down as beats complete, so software can read back how many bytes are left. A finished transfer and an accepted abort both raise event bits. The events are latched into a pending register that is cleared by writing ones, filtered by a mask, and turned into one registered interrupt line per channel. Channels take turns on the memory port in round-robin order.

Scatter-gather walking and descriptor queues are left to software, which reprograms a channel after each chunk.

Top module: `chunk_dma_top`

## Requirements
- R1: A write to the command word at offset 0x000 with bit 31 clear starts every idle channel N whose bit N is one. A start sent to a busy channel is ignored: it issues no extra memory access and does not restart the chunk.
- R2: A command write with bit 31 set aborts each channel whose bit is one. The channel stops with no further beats, and its live status and pending register then read 0x2002 (abort bit 13, done bit 1). This holds for an idle channel too.
- R3: Channel c's window starts at 0x100 + 0x40*c. Its offsets are: live status 0x10, pending 0x14, mask 0x18, masked detect 0x1C, source mode 0x20, destination mode 0x24, source address 0x28, destination address 0x2C, length 0x30. Mode bits [5:4] select the address behaviour: 0 steps up by 4 per beat, 1 steps down by 4 per beat, 2 or 3 holds the address fixed and uses the device port.
- R4: Each beat moves 4 bytes with byte enables 4'hF while the length is 4 or more. A final beat of 1, 2 or 3 bytes uses enables 4'h1, 4'h3 or 4'h7 (low lanes). The length register drops by the bytes moved when the destination side of a beat completes, and reads back as the bytes still left.
- R5: When the last beat completes, or when a chunk is started with length 0, the done bit 1 is set in the live status and pending registers. An accepted start clears the live status bits.
- R6: Writing ones to the pending register clears those bits; an event in the same cycle wins over the clear. The detect register reads pending AND mask.
- R7: A channel's interrupt output is the OR of its detect bits, registered one cycle. It is low whenever detect is zero.
- R8: The memory port is shared round-robin. A channel holds its request, address and data stable until it is acknowledged, and each channel has at most one memory access outstanding.
- R9: Writes to the mode, address and length registers while a channel is busy are ignored.
- R10: After reset all channel registers read zero, every interrupt is low and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Memory byte address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| dev_in_valid | input | NCH | Device word offered to channel c |
| dev_in_ready | output | NCH | Channel c takes a device word |
| dev_in_data | input | NCH*32 | Device words, channel c at bits [32c+31:32c] |
| dev_out_valid | output | NCH | Channel c offers a word to its device |
| dev_out_ready | input | NCH | Device accepts the word |
| dev_out_data | output | NCH*32 | Words to devices |
| dev_out_be | output | NCH*4 | Byte enables of words to devices |
| irq | output | NCH | Per-channel interrupt |

## Verification
The bench runs chunks whose lengths end in full words and in 1, 2 and 3 byte tails, with addresses stepping up, stepping down and held fixed. A wrong tail mask would corrupt bytes next to the chunk in memory or mark the wrong device lanes. A wrong step direction would write the wrong words. The bench stalls a device mid-chunk to look at the live length and at writes made while busy, and it sends a start to the busy channel. A design that restarts on that start shows a fresh memory read, and one that accepts the writes shows a changed length. It also aborts both a stalled channel and an idle one, clears pending bits one at a time with the mask set both ways, and runs two memory-bound channels together. A design without round-robin turns would show one channel's addresses back to back.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned EV_DONE  = 1;
  localparam int unsigned EV_ABORT = 13;
  localparam int unsigned CMD_KILL = 31;

  typedef enum logic [1:0] {CH_IDLE = 2'd0, CH_SRC = 2'd1, CH_DST = 2'd2} ch_state_e;

  // bytes carried by the next beat
  function automatic logic [2:0] beat_bytes(input logic [31:0] left);
    return (left >= 32'd4) ? 3'd4 : left[2:0];
  endfunction

  // low-lane byte enables for a beat of n bytes
  function automatic logic [LANES-1:0] lane_mask(input logic [2:0] n);
    case (n)
      3'd1:    return 4'h1;
      3'd2:    return 4'h3;
      3'd3:    return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  // mode code 2 or 3 means the address does not move (device side)
  function automatic logic is_hold(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic [WORD_W-1:0] evt_word(input logic done, input logic abrt);
    logic [WORD_W-1:0] w;
    w = '0;
    w[EV_DONE]  = done;
    w[EV_ABORT] = abrt;
    return w;
  endfunction
endpackage

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rq,
  input  logic         ack,
  output logic [N-1:0] gnt
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic          lock_q;
  logic [IW-1:0] owner_q, last_q, pick, cur;
  logic          pick_ok, active;

  always_comb begin
    int unsigned cand;
    pick    = '0;
    pick_ok = 1'b0;
    for (int k = 1; k <= int'(N); k++) begin
      cand = (32'(last_q) + 32'(k)) % N;
      if (!pick_ok && rq[cand]) begin
        pick    = IW'(cand);
        pick_ok = 1'b1;
      end
    end
  end

  assign cur    = lock_q ? owner_q : pick;
  assign active = lock_q | pick_ok;
  assign gnt    = active ? (N'(1) << cur) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= '0;
    end else if (active) begin
      if (ack) begin
        lock_q <= 1'b0;
        last_q <= cur;
      end else begin
        lock_q  <= 1'b1;
        owner_q <= cur;
      end
    end
  end

  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt))
    else $error("grant not one-hot");
  p_grant_valid_r8: assert property (@(posedge clk) disable iff (!rst_n) (|gnt) |-> (|(gnt & rq)))
    else $error("grant to a non-requesting channel");
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [5:0]        cfg_off,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              start_i,
  input  logic              abort_i,
  output logic              mem_rq_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              dev_in_valid_i,
  output logic              dev_in_ready_o,
  input  logic [WORD_W-1:0] dev_in_data_i,
  output logic              dev_out_valid_o,
  input  logic              dev_out_ready_i,
  output logic [WORD_W-1:0] dev_out_data_o,
  output logic [LANES-1:0]  dev_out_be_o,
  output logic              irq_o
);
  localparam logic [5:0] OFF_LIVE = 6'h10, OFF_PEND = 6'h14, OFF_MASK = 6'h18, OFF_SEEN = 6'h1C;
  localparam logic [5:0] OFF_SCFG = 6'h20, OFF_DCFG = 6'h24, OFF_SPTR = 6'h28, OFF_DPTR = 6'h2C;
  localparam logic [5:0] OFF_LEN  = 6'h30;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] a, input logic [1:0] m);
    if (is_hold(m)) return a;
    return m[0] ? (a - AW'(4)) : (a + AW'(4));
  endfunction

  ch_state_e         state;
  logic [1:0]        src_mode, dst_mode;
  logic [AW-1:0]     src_ptr, dst_ptr;
  logic [LW-1:0]     len, len_left;
  logic [WORD_W-1:0] hold_word;
  logic              st_done, st_abort, pd_done, pd_abort, mk_done, mk_abort;
  logic              abort_pend, irq_q;

  // named events for assertions
  logic [2:0]       nbytes;
  logic [LANES-1:0] be;
  logic src_mem, dst_mem, src_fire, dst_fire, last_beat, stop, start_ok, finish;
  logic ev_done, ev_abort, idle, clr_wr;
  logic [1:0] det;

  assign idle      = (state == CH_IDLE);
  assign nbytes    = beat_bytes(32'(len));
  assign be        = lane_mask(nbytes);
  assign len_left  = len - LW'(nbytes);
  assign last_beat = (len_left == '0);
  assign src_mem   = !is_hold(src_mode);
  assign dst_mem   = !is_hold(dst_mode);

  assign mem_rq_o    = ((state == CH_SRC) && src_mem) || ((state == CH_DST) && dst_mem);
  assign mem_we_o    = (state == CH_DST);
  assign mem_addr_o  = (state == CH_DST) ? dst_ptr : src_ptr;
  assign mem_be_o    = be;
  assign mem_wdata_o = hold_word;

  assign dev_in_ready_o  = (state == CH_SRC) && !src_mem;
  assign dev_out_valid_o = (state == CH_DST) && !dst_mem;
  assign dev_out_data_o  = hold_word;
  assign dev_out_be_o    = be;

  assign src_fire = (state == CH_SRC) && (src_mem ? mem_ack_i : dev_in_valid_i);
  assign dst_fire = (state == CH_DST) && (dst_mem ? mem_ack_i : dev_out_ready_i);
  assign stop     = abort_pend && (!mem_rq_o || mem_ack_i);
  assign start_ok = start_i && !abort_i && idle && !abort_pend;
  assign finish   = dst_fire && last_beat && !stop;
  assign ev_abort = stop;
  assign ev_done  = finish || stop || (start_ok && (len == '0));
  assign clr_wr   = cfg_we && (cfg_off == OFF_PEND);
  assign det      = {pd_abort & mk_abort, pd_done & mk_done};
  assign irq_o    = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= CH_IDLE;
    else if (stop) state <= CH_IDLE;
    else begin
      case (state)
        CH_IDLE: if (start_ok && (len != '0)) state <= CH_SRC;
        CH_SRC:  if (src_fire) state <= CH_DST;
        CH_DST:  if (dst_fire) state <= last_beat ? CH_IDLE : CH_SRC;
        default: state <= CH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_mode <= '0; dst_mode <= '0; src_ptr <= '0; dst_ptr <= '0;
      len <= '0; hold_word <= '0;
    end else begin
      if (src_fire) hold_word <= src_mem ? mem_rdata_i : dev_in_data_i;
      if (dst_fire) begin
        len     <= len_left;
        src_ptr <= step_ptr(src_ptr, src_mode);
        dst_ptr <= step_ptr(dst_ptr, dst_mode);
      end else if (cfg_we && idle) begin
        case (cfg_off)
          OFF_SCFG: src_mode <= cfg_wdata[5:4];
          OFF_DCFG: dst_mode <= cfg_wdata[5:4];
          OFF_SPTR: src_ptr  <= cfg_wdata[AW-1:0];
          OFF_DPTR: dst_ptr  <= cfg_wdata[AW-1:0];
          OFF_LEN:  len      <= cfg_wdata[LW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_done <= 1'b0; st_abort <= 1'b0; pd_done <= 1'b0; pd_abort <= 1'b0;
      mk_done <= 1'b0; mk_abort <= 1'b0; abort_pend <= 1'b0; irq_q <= 1'b0;
    end else begin
      st_done  <= (st_done  && !start_ok) || ev_done;
      st_abort <= (st_abort && !start_ok) || ev_abort;
      pd_done  <= (pd_done  && !(clr_wr && cfg_wdata[EV_DONE]))  || ev_done;
      pd_abort <= (pd_abort && !(clr_wr && cfg_wdata[EV_ABORT])) || ev_abort;
      if (cfg_we && (cfg_off == OFF_MASK)) begin
        mk_done  <= cfg_wdata[EV_DONE];
        mk_abort <= cfg_wdata[EV_ABORT];
      end
      if (abort_i) abort_pend <= 1'b1;
      else if (stop) abort_pend <= 1'b0;
      irq_q <= |det;
    end
  end

  always_comb begin
    case (cfg_off)
      OFF_LIVE: cfg_rdata = evt_word(st_done, st_abort);
      OFF_PEND: cfg_rdata = evt_word(pd_done, pd_abort);
      OFF_MASK: cfg_rdata = evt_word(mk_done, mk_abort);
      OFF_SEEN: cfg_rdata = evt_word(det[0], det[1]);
      OFF_SCFG: cfg_rdata = WORD_W'({src_mode, 4'b0});
      OFF_DCFG: cfg_rdata = WORD_W'({dst_mode, 4'b0});
      OFF_SPTR: cfg_rdata = WORD_W'(src_ptr);
      OFF_DPTR: cfg_rdata = WORD_W'(dst_ptr);
      OFF_LEN:  cfg_rdata = WORD_W'(len);
      default:  cfg_rdata = '0;
    endcase
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rq_o && !mem_ack_i |=> mem_rq_o && $stable(mem_addr_o) && $stable(mem_wdata_o))
    else $error("memory request dropped or changed before ack");
  p_len_no_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> len <= $past(len))
    else $error("length grew while busy");
  p_abort_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> st_abort && st_done && pd_abort && pd_done && idle)
    else $error("abort did not raise both events");
  p_done_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> st_done && pd_done && idle)
    else $error("last beat did not raise done");
  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    det == 2'b00 |=> !irq_o)
    else $error("interrupt high with empty detect");
endmodule

// File: rtl/chunk_dma_top.sv
module chunk_dma_top
  import dma_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 32,
  parameter int unsigned LW  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [11:0]             reg_addr,
  input  logic [WORD_W-1:0]       reg_wdata,
  output logic [WORD_W-1:0]       reg_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [LANES-1:0]        mem_be,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [WORD_W-1:0]       mem_rdata,
  input  logic [NCH-1:0]          dev_in_valid,
  output logic [NCH-1:0]          dev_in_ready,
  input  logic [NCH*WORD_W-1:0]   dev_in_data,
  output logic [NCH-1:0]          dev_out_valid,
  input  logic [NCH-1:0]          dev_out_ready,
  output logic [NCH*WORD_W-1:0]   dev_out_data,
  output logic [NCH*LANES-1:0]    dev_out_be,
  output logic [NCH-1:0]          irq
);
  localparam logic [5:0] WIN_BASE = 6'h04; // 0x100 >> 6

  logic              cmd_hit;
  logic [NCH-1:0]    win_hit, ch_rq, ch_we, gnt;
  logic [AW-1:0]     ch_addr  [NCH];
  logic [LANES-1:0]  ch_be    [NCH];
  logic [WORD_W-1:0] ch_wdata [NCH];
  logic [WORD_W-1:0] ch_rd    [NCH];

  assign cmd_hit = reg_we && (reg_addr == 12'h000);

  dma_rr_arb #(.N(NCH)) i_arb (.clk(clk), .rst_n(rst_n), .rq(ch_rq), .ack(mem_ack), .gnt(gnt));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign win_hit[c] = (reg_addr[11:6] == (WIN_BASE + 6'(c)));
    dma_chan #(.AW(AW), .LW(LW)) i_chan (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(reg_we && win_hit[c]), .cfg_off(reg_addr[5:0]), .cfg_wdata(reg_wdata),
      .cfg_rdata(ch_rd[c]),
      .start_i(cmd_hit && reg_wdata[c] && !reg_wdata[CMD_KILL]),
      .abort_i(cmd_hit && reg_wdata[c] && reg_wdata[CMD_KILL]),
      .mem_rq_o(ch_rq[c]), .mem_we_o(ch_we[c]), .mem_addr_o(ch_addr[c]),
      .mem_be_o(ch_be[c]), .mem_wdata_o(ch_wdata[c]),
      .mem_ack_i(mem_ack && gnt[c]), .mem_rdata_i(mem_rdata),
      .dev_in_valid_i(dev_in_valid[c]), .dev_in_ready_o(dev_in_ready[c]),
      .dev_in_data_i(dev_in_data[c*WORD_W +: WORD_W]),
      .dev_out_valid_o(dev_out_valid[c]), .dev_out_ready_i(dev_out_ready[c]),
      .dev_out_data_o(dev_out_data[c*WORD_W +: WORD_W]),
      .dev_out_be_o(dev_out_be[c*LANES +: LANES]),
      .irq_o(irq[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    mem_we = 1'b0; mem_addr = '0; mem_be = '0; mem_wdata = '0;
    for (int c = 0; c < int'(NCH); c++) begin
      if (win_hit[c]) reg_rdata = reg_rdata | ch_rd[c];
      if (gnt[c]) begin
        mem_we    = mem_we | ch_we[c];
        mem_addr  = mem_addr | ch_addr[c];
        mem_be    = mem_be | ch_be[c];
        mem_wdata = mem_wdata | ch_wdata[c];
      end
    end
  end
  assign mem_req = |gnt;

  p_port_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we))
    else $error("shared memory port changed before ack");
  p_tail_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be == 4'h1 || mem_be == 4'h3 || mem_be == 4'h7 || mem_be == 4'hF))
    else $error("illegal byte enable pattern");
endmodule

// File: tb/test_chunk_dma_top.sv
module test_chunk_dma_top;
  localparam int NCH = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [NCH-1:0] dev_in_valid, dev_in_ready, dev_out_valid, dev_out_ready, irq;
  logic [NCH*32-1:0] dev_in_data, dev_out_data;
  logic [NCH*4-1:0] dev_out_be;
  logic [NCH-1:0] dout_rdy = '1;

  logic [31:0] mem [512];
  logic mack;
  int unsigned incnt [NCH];
  int ccnt [NCH];
  logic [31:0] cap_d [NCH][64];
  logic [3:0] cap_b [NCH][64];
  logic log_on = 1'b0;
  logic [31:0] alog [8];
  int nlog = 0;
  int total = 0, bad = 0, cyc = 0;

  chunk_dma_top #(.NCH(NCH)) i_chunk_dma_top (.*);

  function automatic logic [31:0] minit(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0003;
  endfunction
  function automatic logic [31:0] dword(int c, int k);
    return 32'hD000_0000 | (32'(c) << 16) | 32'(k[15:0]);
  endfunction
  function automatic logic [31:0] bmask(logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction
  function automatic logic [31:0] addr_at(logic [31:0] a, logic [1:0] m, int k);
    if (m == 2'd0) return a + 32'(4 * k);
    if (m == 2'd1) return a - 32'(4 * k);
    return a;
  endfunction

  assign dev_in_valid  = '1;
  assign dev_out_ready = dout_rdy;
  assign mem_ack       = mack;
  assign mem_rdata     = mem[mem_addr[10:2]];
  always_comb
    for (int c = 0; c < NCH; c++) dev_in_data[c*32 +: 32] = dword(c, int'(incnt[c]));

  always @(posedge clk) begin
    if (!rst_n) mack <= 1'b0;
    else mack <= mem_req && !mack;
    if (rst_n && mem_req && mack) begin
      if (mem_we) mem[mem_addr[10:2]] <= (mem[mem_addr[10:2]] & ~bmask(mem_be)) | (mem_wdata & bmask(mem_be));
      if (log_on && nlog < 8) begin alog[nlog] <= mem_addr; nlog <= nlog + 1; end
    end
    for (int c = 0; c < NCH; c++) begin
      if (dev_in_valid[c] && dev_in_ready[c]) incnt[c] <= incnt[c] + 1;
      if (dev_out_valid[c] && dev_out_ready[c]) begin
        cap_d[c][ccnt[c] % 64] <= dev_out_data[c*32 +: 32];
        cap_b[c][ccnt[c] % 64] <= dev_out_be[c*4 +: 4];
        ccnt[c] <= ccnt[c] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      total = total + 1; bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  task automatic wait_irq(input int c);
    int n = 0;
    while (!irq[c] && n < 2000) begin @(negedge clk); n++; end
    chk(irq[c] == 1'b1, "R7 irq after done", 32'(irq[c]), 32'h1);
  endtask
  task automatic cfg(input int c, input logic [1:0] sm, input logic [1:0] dm,
                     input logic [31:0] sa, input logic [31:0] da, input logic [31:0] ln);
    logic [11:0] wb;
    wb = 12'h100 + 12'(c * 'h40);
    wr(wb + 12'h20, 32'(sm) << 4); wr(wb + 12'h24, 32'(dm) << 4);
    wr(wb + 12'h28, sa); wr(wb + 12'h2C, da); wr(wb + 12'h30, ln);
    wr(wb + 12'h18, 32'h2002); wr(wb + 12'h14, 32'h2002);
  endtask

  // {ch, src mode, dst mode, src addr, dst addr, length}
  localparam logic [36:0] VEC [5] = '{
    {1'b0, 2'd0, 2'd2, 12'h040, 12'h000, 8'd10},
    {1'b1, 2'd2, 2'd0, 12'h000, 12'h200, 8'd8},
    {1'b0, 2'd2, 2'd1, 12'h000, 12'h300, 8'd6},
    {1'b1, 2'd0, 2'd0, 12'h010, 12'h100, 8'd4},
    {1'b0, 2'd1, 2'd2, 12'h0F0, 12'h000, 8'd7}
  };

  initial begin
    logic [36:0] e;
    int ch, ln, nb, tl, c0, d0, bad_alt;
    logic [1:0] sm, dm;
    logic [3:0] lm;
    logic [31:0] sl, dl, pre_d, pre_s, v, data;
    logic [11:0] wb;
    for (int i = 0; i < 512; i++) mem[i] = minit(i);
    for (int c = 0; c < NCH; c++) begin incnt[c] = 0; ccnt[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    rd(12'h110, v); chk(v == 0, "R10 live status after reset", v, 0);
    rd(12'h130, v); chk(v == 0, "R10 length after reset", v, 0);
    chk(irq == 0 && mem_req == 0, "R10 irq and request idle", {irq, mem_req}, 0);

    // vector table: R3 R4 R5
    for (int vi = 0; vi < 5; vi++) begin
      e = VEC[vi];
      ch = int'(e[36]); sm = e[35:34]; dm = e[33:32]; ln = int'(e[7:0]);
      wb = 12'h100 + 12'(ch * 'h40);
      cfg(ch, sm, dm, 32'(e[31:20]), 32'(e[19:8]), 32'(ln));
      nb = (ln + 3) / 4; tl = ln % 4;
      lm = (tl == 0) ? 4'hF : 4'((1 << tl) - 1);
      sl = addr_at(32'(e[31:20]), sm, nb - 1);
      dl = addr_at(32'(e[19:8]), dm, nb - 1);
      pre_d = mem[dl[10:2]]; pre_s = mem[sl[10:2]];
      c0 = ccnt[ch]; d0 = int'(incnt[ch]);
      wr(12'h000, 32'(1) << ch);
      wait_irq(ch);
      if (dm[1]) begin
        chk(ccnt[ch] - c0 == nb, "R3 device beat count", 32'(ccnt[ch] - c0), 32'(nb));
        chk(cap_d[ch][(ccnt[ch] - 1) % 64] == pre_s, "R3 device last word", cap_d[ch][(ccnt[ch] - 1) % 64], pre_s);
        chk(cap_b[ch][(ccnt[ch] - 1) % 64] == lm, "R4 tail byte enables", 32'(cap_b[ch][(ccnt[ch] - 1) % 64]), 32'(lm));
      end else begin
        data = sm[1] ? dword(ch, d0 + nb - 1) : pre_s;
        v = (pre_d & ~bmask(lm)) | (data & bmask(lm));
        chk(mem[dl[10:2]] == v, "R4 memory last word merge", mem[dl[10:2]], v);
      end
      rd(wb + 12'h30, v); chk(v == 0, "R4 length drained", v, 0);
      rd(wb + 12'h10, v); chk(v == 32'h2, "R5 done status", v, 32'h2);
    end

    // stalled channel: R1 R4 R9 then abort R2
    dout_rdy[0] = 1'b0;
    cfg(0, 2'd0, 2'd2, 32'h080, 32'h0, 32'd12);
    c0 = ccnt[0];
    wr(12'h000, 32'h1);
    repeat (10) @(negedge clk);
    rd(12'h130, v); chk(v == 12, "R4 live length before first write", v, 12);
    wr(12'h130, 32'd99);
    rd(12'h130, v); chk(v == 12, "R9 length write while busy", v, 12);
    wr(12'h000, 32'h1);
    bad_alt = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (mem_req) bad_alt++; end
    chk(bad_alt == 0, "R1 busy start ignored", 32'(bad_alt), 0);
    @(negedge clk); dout_rdy[0] = 1'b1;
    @(negedge clk); dout_rdy[0] = 1'b0;
    repeat (6) @(negedge clk);
    rd(12'h130, v); chk(v == 8, "R4 live length after one beat", v, 8);
    chk(ccnt[0] - c0 == 1, "R4 one beat delivered", 32'(ccnt[0] - c0), 1);
    wr(12'h000, 32'h8000_0001);
    repeat (2) @(negedge clk);
    rd(12'h110, v); chk(v == 32'h2002, "R2 abort live status", v, 32'h2002);
    rd(12'h114, v); chk(v == 32'h2002, "R2 abort pending", v, 32'h2002);
    chk(irq[0] == 1'b1, "R7 irq on abort", 32'(irq[0]), 1);
    repeat (4) @(negedge clk);
    rd(12'h130, v); chk(v == 8, "R2 no beat after abort", v, 8);
    dout_rdy[0] = 1'b1;

    // R6 R7 clear and mask
    wr(12'h114, 32'h2);
    rd(12'h114, v); chk(v == 32'h2000, "R6 partial clear", v, 32'h2000);
    wr(12'h118, 32'h2);
    rd(12'h11C, v); chk(v == 0, "R6 detect masked", v, 0);
    repeat (2) @(negedge clk);
    chk(irq[0] == 1'b0, "R7 irq low with empty detect", 32'(irq[0]), 0);
    wr(12'h118, 32'h2000);
    rd(12'h11C, v); chk(v == 32'h2000, "R6 detect unmasked", v, 32'h2000);
    repeat (2) @(negedge clk);
    chk(irq[0] == 1'b1, "R7 irq from abort bit", 32'(irq[0]), 1);
    wr(12'h114, 32'h2000);
    repeat (2) @(negedge clk);
    rd(12'h114, v); chk(v == 0 && irq[0] == 1'b0, "R6 full clear", {v[30:0], irq[0]}, 0);

    // R2 idle abort, R5 zero-length start
    wr(12'h000, 32'h8000_0002);
    repeat (2) @(negedge clk);
    rd(12'h150, v); chk(v == 32'h2002, "R2 idle abort status", v, 32'h2002);
    wr(12'h170, 32'h0);
    wr(12'h000, 32'h2);
    repeat (2) @(negedge clk);
    rd(12'h150, v); chk(v == 32'h2, "R5 zero-length done", v, 32'h2);

    // R8 round-robin
    cfg(0, 2'd0, 2'd2, 32'h400, 32'h0, 32'd16);
    cfg(1, 2'd0, 2'd2, 32'h600, 32'h0, 32'd16);
    @(negedge clk); log_on = 1'b1;
    wr(12'h000, 32'h3);
    wait_irq(0); wait_irq(1);
    bad_alt = 0;
    for (int i = 1; i < 6; i++) if (alog[i][9] == alog[i-1][9]) bad_alt++;
    chk(bad_alt == 0 && nlog >= 6, "R8 alternating grants", 32'(bad_alt), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule